// File: doc/BRIEF.md
# I2C Command Slave Port

This block lets a host controller push command bytes into a signal processor and read short status codes back over a two-wire I2C bus. It acts only as a slave: the host always drives SCL and starts every transfer. Both bus lines are oversampled with the system clock through two-flop synchronisers. START and STOP are recognised on the synchronised lines, so the same logic serves 100 kbit/s and 400 kbit/s traffic.

The 7-bit slave address has a fixed upper part, `00111`, and two low bits taken from strap inputs. After a write address, each received byte is acknowledged and handed to the core as a single-cycle strobe with the data. After a read address, the slave returns a status byte `0x80 + status_sel`. The slave never drives SDA high. It only pulls the line low through `sda_oe` or releases it.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The slave answers the address whose bits, MSB first, are 0,0,1,1,1,`addr_lsb[1]`,`addr_lsb[0]`. The R/W bit follows the address: 0 is a write and 1 is a read. On a match the slave pulls SDA low (`sda_oe`=1) for the whole SCL-high phase of the ninth bit.
- R2: After an address that does not match, the slave keeps `sda_oe`=0 and raises no `rx_valid` for any later bits. This holds until the next START.
- R3: During a write, each byte is shifted in MSB first on SCL rising edges. After its eighth bit, `rx_data` carries the byte and `rx_valid` is high for exactly one clock. The ninth bit is acknowledged with `sda_oe`=1.
- R4: During a read, the byte sent MSB first is `{6'b100000, status_sel}`. This gives 0x80 for accepted, 0x81 for error, 0x82 for processing and 0x83 for not ready. `sda_oe` is 1 exactly for the zero bits. No `rx_valid` occurs while reading.
- R5: If the host acknowledges a read byte (SDA low in its ninth bit), the next byte is built from `status_sel` as sampled at that ninth-bit SCL rise. If the host does not acknowledge, the slave releases SDA and stays silent until the next START.
- R6: The slave powers up and resets with SDA released. A STOP (SDA rising while SCL is high) releases SDA and returns the slave to idle, including in the middle of a byte, and a partial byte is not delivered. A repeated START begins a new address phase.
- R7: While SCL stays high, `sda_oe` does not change unless a START or STOP is seen.
- R8: Transfers work with both 100 kbit/s and 400 kbit/s bus timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_lsb | input | 2 | Strap bits forming the two low address bits |
| status_sel | input | 2 | Status code selector, read byte is 0x80 plus this value |
| rx_data | output | 8 | Last byte written by the host |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |

## Verification
The assertions assume that SDA changes only while SCL is low, except at START and STOP. They also assume each SCL phase lasts many system clocks longer than the synchroniser delay, and that the host never drives SDA against a slave that is pulling it low. The stimulus keeps within these limits. The bench host moves SDA only a quarter bit period after SCL falls and holds each SCL level for half a bit period, at 125 or 500 clocks per quarter. It resolves SDA as a wired-AND of its own drive and the slave's pull-down, and it issues STOP only after the slave has released the line.

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
  parameter logic [4:0] ADDR_HI = 5'b00111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_lsb,
  input  logic [1:0] status_sel,
  output logic [7:0] rx_data,
  output logic       rx_valid
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK, S_SKIP
  } st_t;

  st_t        state;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [7:0] shreg, rd_byte;
  logic [2:0] cnt;
  logic       rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;

  wire [7:0] status_byte = {6'b100000, status_sel};
  wire [7:0] sh_next     = {shreg[6:0], sda_s};
  wire       addr_hit    = (sh_next[7:1] == {ADDR_HI, addr_lsb});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sda_oe   <= 1'b0;
      shreg    <= '0;
      rd_byte  <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start_det) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          S_ADDR: begin
            shreg <= sh_next;
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (addr_hit) begin
                state <= S_AACK;
                rw    <= sh_next[0];
              end else begin
                state <= S_SKIP;
              end
            end
          end
          S_WR: begin
            shreg <= sh_next;
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              rx_data  <= sh_next;
              rx_valid <= 1'b1;
              state    <= S_WACK;
            end
          end
          S_RD: begin
            if (cnt == 3'd7) state <= S_RACK;
            else             cnt   <= cnt + 3'd1;
          end
          S_RACK: begin
            if (sda_s) begin
              state <= S_SKIP;
            end else begin
              rd_byte <= status_byte;
              cnt     <= '0;
              state   <= S_RD;
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          S_AACK: begin
            if (!sda_oe) begin
              sda_oe <= 1'b1;
            end else if (rw) begin
              state   <= S_RD;
              cnt     <= '0;
              rd_byte <= status_byte;
              sda_oe  <= ~status_byte[7];
            end else begin
              state  <= S_WR;
              cnt    <= '0;
              sda_oe <= 1'b0;
            end
          end
          S_WACK: begin
            if (!sda_oe) begin
              sda_oe <= 1'b1;
            end else begin
              state  <= S_WR;
              cnt    <= '0;
              sda_oe <= 1'b0;
            end
          end
          S_RD:    sda_oe <= ~rd_byte[3'd7 - cnt];
          S_RACK:  sda_oe <= 1'b0;
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> (!sda_oe && !rx_valid));

  assert_rx_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_read_no_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD || state == S_RACK) |-> !rx_valid);

  assert_rack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RACK && scl_fall && !start_det && !stop_det) |=> !sda_oe);

  assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && state == S_IDLE));

  assert_sda_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !start_det && !stop_det) |=> $stable(sda_oe));

endmodule

// File: tb/i2c_cmd_slave_tb.sv
`timescale 1ns/1ps
module i2c_cmd_slave_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] addr_lsb = 2'b10;
  logic [1:0] status_sel = 2'b00;
  wire        sda_oe;
  wire  [7:0] rx_data;
  wire        rx_valid;
  wire        sda_line = sda_m & ~sda_oe;

  i2c_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_lsb(addr_lsb), .status_sel(status_sel), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  int         n_cmp = 0, n_bad = 0, cyc = 0, Q = 125;
  logic       chk_en = 1'b0, exp_oe = 1'b0;
  string      cur_req = "R6";
  logic [7:0] exp_q[$];

  task automatic chk(string r, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (chk_en) chk(cur_req, "sda_oe", int'(sda_oe), int'(exp_oe));
    if (rx_valid === 1'b1) begin
      if (exp_q.size() == 0) chk("R3", "unexpected rx_valid", int'(rx_data), -1);
      else chk("R3", "rx_data", int'(rx_data), int'(exp_q.pop_front()));
    end
    if (cyc > 195000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, 195000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, input logic e, output logic seen);
    wt(Q); sda_m = b;
    wt(Q); scl = 1'b1;
    wt(8); exp_oe = e; chk_en = 1'b1;
    wt(Q - 8); seen = sda_line;
    wt(Q - 16); chk_en = 1'b0;
    wt(8); scl = 1'b0;
  endtask

  task automatic start_c();
    if (scl == 1'b0) begin
      wt(Q); sda_m = 1'b1;
      wt(Q); scl = 1'b1;
    end
    wt(Q); sda_m = 1'b0;
    wt(Q); scl = 1'b0;
  endtask

  task automatic stop_c();
    wt(Q); sda_m = 1'b0;
    wt(Q); scl = 1'b1;
    wt(Q); sda_m = 1'b1;
    wt(8); exp_oe = 1'b0; chk_en = 1'b1;
    wt(Q); chk_en = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] v, input logic ack, input logic push);
    logic s;
    if (push) exp_q.push_back(v);
    for (int i = 7; i >= 0; i--) bit_x(v[i], 1'b0, s);
    bit_x(1'b1, ack, s);
  endtask

  task automatic read_byte(input logic [7:0] v, input logic mack, input logic [1:0] nsel,
                           input logic active);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, active ? ~v[i] : 1'b0, s);
      if (active) chk("R4", "read bit", int'(s), int'(v[i]));
    end
    status_sel = nsel;
    bit_x(mack, 1'b0, s);
  endtask

  initial begin
    logic s;
    wt(5);
    rst_n = 1'b1;
    wt(4);
    chk("R6", "reset sda_oe", int'(sda_oe), 0);
    chk("R6", "reset rx_valid", int'(rx_valid), 0);

    cur_req = "R1";
    start_c(); write_byte(8'h3C, 1'b1, 1'b0);
    cur_req = "R3";
    write_byte(8'hA5, 1'b1, 1'b1);
    write_byte(8'h5A, 1'b1, 1'b1);
    write_byte(8'h00, 1'b1, 1'b1);
    stop_c();

    cur_req = "R2";
    start_c(); write_byte(8'h3E, 1'b0, 1'b0);
    write_byte(8'hFF, 1'b0, 1'b0);
    write_byte(8'h12, 1'b0, 1'b0);
    stop_c();

    cur_req = "R4";
    status_sel = 2'd3;
    start_c(); write_byte(8'h3D, 1'b1, 1'b0);
    read_byte(8'h83, 1'b0, 2'd0, 1'b1);
    cur_req = "R5";
    read_byte(8'h80, 1'b0, 2'd1, 1'b1);
    read_byte(8'h81, 1'b1, 2'd2, 1'b1);
    read_byte(8'h00, 1'b1, 2'd2, 1'b0);
    stop_c();

    cur_req = "R6";
    start_c(); write_byte(8'h3C, 1'b1, 1'b0);
    write_byte(8'h11, 1'b1, 1'b1);
    start_c(); write_byte(8'h3D, 1'b1, 1'b0);
    read_byte(8'h82, 1'b1, 2'd0, 1'b1);
    stop_c();

    start_c(); write_byte(8'h3C, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) bit_x(1'b1, 1'b0, s);
    stop_c();

    cur_req = "R1";
    addr_lsb = 2'b01;
    start_c(); write_byte(8'h3A, 1'b1, 1'b0);
    write_byte(8'hC3, 1'b1, 1'b1);
    start_c(); write_byte(8'h3C, 1'b0, 1'b0);
    stop_c();

    cur_req = "R8";
    Q = 500;
    status_sel = 2'd1;
    start_c(); write_byte(8'h3A, 1'b1, 1'b0);
    write_byte(8'h96, 1'b1, 1'b1);
    start_c(); write_byte(8'h3B, 1'b1, 1'b0);
    read_byte(8'h81, 1'b1, 2'd1, 1'b1);
    stop_c();

    wt(20);
    chk("R3", "pending bytes", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule